// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This combinational block sits in front of the arithmetic datapath of a double-precision fused multiply-add unit that computes addend + (multiplicand X × multiplicand Y). It takes the three raw 64-bit IEEE-754 operands and sorts each one into a class: zero, denormal, normal, infinity, quiet NaN or signalling NaN. It then decides whether one of the special cases already fixes the result. When a special case applies, it raises a bypass flag and supplies the finished 64-bit result. When no special case applies, the bypass flag stays low and the operation goes to the mantissa datapath.

The block resolves NaN and infinity priority across all three operands. A signalling-NaN addend is handled first. The two multiplicands come next, and a NaN in either multiplicand wins over a quiet-NaN addend. After that come the invalid product infinity × zero, an infinite product, a zero product, and a finite product meeting a special addend. Separately from the bypass decision, each operand whose class is denormal raises a pre-normalisation request for the datapath. The invalid-operation flag depends only on the current operands; nothing carries over from an earlier operation.

Top module: `fma_special_resolver`

## Requirements
- R1: Each operand has a pre-normalisation flag that is 1 exactly when that operand is denormal (exponent field zero and mantissa nonzero). The flag does not depend on the other operands or on the bypass decision.
- R2: A signalling-NaN addend takes precedence over every other case. The block bypasses with the addend made quiet and raises invalid. A NaN is signalling when the exponent is all ones, the mantissa is nonzero and mantissa bit 51 is 0; quieting sets bit 51 and leaves all other bits unchanged.
- R3: Otherwise a signalling-NaN X gives the quieted X. If X is not a signalling NaN, a signalling-NaN Y gives the quieted Y. Both cases bypass and raise invalid.
- R4: Otherwise a quiet-NaN X (exponent all ones, bit 51 set) is returned unchanged. If X is not a NaN, a quiet-NaN Y is returned unchanged. Both cases bypass without invalid, and they win even when the addend is also a quiet NaN.
- R5: Infinity × zero, in either order, returns a quiet-NaN addend unchanged without invalid. With any other addend it returns the default NaN 0x7FF8000000000000 and raises invalid.
- R6: Infinity × a nonzero non-NaN value (normal, denormal or infinity) returns a quiet-NaN addend unchanged. An infinite addend whose sign differs from sign(X) XOR sign(Y) gives the default NaN with invalid. In every other case the result is infinity (exponent all ones, mantissa zero) with sign sign(X) XOR sign(Y).
- R7: Zero × a finite value (zero, denormal or normal) returns the addend. An infinite addend is returned as infinity with the addend's sign. No invalid is raised.
- R8: When both multiplicands are finite and nonzero, a quiet-NaN addend is returned unchanged and an infinite addend is returned as infinity with its own sign, both as bypass. Any other addend gives bypass = 0, result = 0 and invalid = 0.
- R9: Invalid is raised only by the cases in R2, R3, R5 and R6. It is always accompanied by bypass, and it is 0 for the next operation that is not itself invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addend_i | input | 64 | Raw IEEE-754 double addend |
| mulx_i | input | 64 | Raw IEEE-754 double multiplicand X |
| muly_i | input | 64 | Raw IEEE-754 double multiplicand Y |
| bypass_o | output | 1 | The result is fixed by a special case |
| result_o | output | 64 | Special-case result, zero when not bypassed |
| invalid_o | output | 1 | Invalid-operation exception |
| prenorm_z_o | output | 1 | Addend is denormal and needs pre-normalisation |
| prenorm_x_o | output | 1 | X is denormal and needs pre-normalisation |
| prenorm_y_o | output | 1 | Y is denormal and needs pre-normalisation |

## Verification
The main stimulus is a full cross product of a twelve-value operand set, placed in all three positions. The set holds both signs of zero, normal, denormal and infinity, plus quiet and signalling NaNs with distinct payloads. Because the payloads differ, the expected result shows which operand's NaN won, so every ordering in the priority chain is told apart. A run of directed vectors covers the remaining corners. These are infinity × zero with and without a quiet-NaN addend, infinite products meeting an infinite addend of the same sign and of the opposite sign, and zero products meeting an infinite addend. They also place an invalid operation directly before a clean one, which shows that the exception flag does not linger.

// File: rtl/fma_special_pkg.sv
package fma_special_pkg;

    localparam int DW      = 64;
    localparam int EW      = 11;
    localparam int MW      = 52;
    localparam int QBIT    = MW - 1;
    localparam int NUM_OPS = 3;
    localparam int OP_Z    = 0;
    localparam int OP_X    = 1;
    localparam int OP_Y    = 2;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_DENORM,
        CLS_NORMAL,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN
    } fp_class_e;

    typedef struct packed {
        logic           sign;
        logic [EW-1:0]  expo;
        logic [MW-1:0]  mant;
    } fp_bits_t;

    typedef struct packed {
        fp_class_e      cls;
        logic           sign;
        logic [DW-1:0]  raw;
    } fp_info_t;

    localparam logic [DW-1:0] DEFAULT_NAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

    function automatic logic [DW-1:0] make_quiet(input logic [DW-1:0] v);
        logic [DW-1:0] q;
        q       = v;
        q[QBIT] = 1'b1;
        return q;
    endfunction

    function automatic logic [DW-1:0] inf_of(input logic s);
        return {s, {EW{1'b1}}, {MW{1'b0}}};
    endfunction

    function automatic logic is_nan(input fp_class_e c);
        return (c == CLS_QNAN) || (c == CLS_SNAN);
    endfunction

    function automatic logic is_finite_nonzero(input fp_class_e c);
        return (c == CLS_NORMAL) || (c == CLS_DENORM);
    endfunction

endpackage

// File: rtl/fma_operand_classify.sv
module fma_operand_classify
    import fma_special_pkg::*;
(
    input  logic [DW-1:0] raw_i,
    output fp_info_t      info_o,
    output logic          denorm_o
);

    fp_bits_t  fields;
    fp_class_e cls;
    logic      exp_ones;
    logic      exp_zero;
    logic      man_zero;

    assign fields   = fp_bits_t'(raw_i);
    assign exp_ones = &fields.expo;
    assign exp_zero = ~|fields.expo;
    assign man_zero = ~|fields.mant;

    always_comb begin
        if (exp_ones) begin
            if (man_zero)               cls = CLS_INF;
            else if (fields.mant[QBIT]) cls = CLS_QNAN;
            else                        cls = CLS_SNAN;
        end else if (exp_zero) begin
            cls = man_zero ? CLS_ZERO : CLS_DENORM;
        end else begin
            cls = CLS_NORMAL;
        end
    end

    assign info_o.cls  = cls;
    assign info_o.sign = fields.sign;
    assign info_o.raw  = raw_i;
    assign denorm_o    = (cls == CLS_DENORM);

endmodule

// File: rtl/fma_special_select.sv
module fma_special_select
    import fma_special_pkg::*;
(
    input  fp_info_t      z_i,
    input  fp_info_t      x_i,
    input  fp_info_t      y_i,
    output logic          bypass_o,
    output logic [DW-1:0] value_o,
    output logic          invalid_o
);

    logic prod_sign;
    logic x_inf, y_inf, x_zero, y_zero, z_qnan, z_inf;
    logic any_snan;

    assign prod_sign = x_i.sign ^ y_i.sign;
    assign x_inf     = (x_i.cls == CLS_INF);
    assign y_inf     = (y_i.cls == CLS_INF);
    assign x_zero    = (x_i.cls == CLS_ZERO);
    assign y_zero    = (y_i.cls == CLS_ZERO);
    assign z_qnan    = (z_i.cls == CLS_QNAN);
    assign z_inf     = (z_i.cls == CLS_INF);
    assign any_snan  = (z_i.cls == CLS_SNAN) || (x_i.cls == CLS_SNAN) || (y_i.cls == CLS_SNAN);

    always_comb begin
        bypass_o  = 1'b1;
        invalid_o = 1'b0;
        value_o   = '0;
        if (z_i.cls == CLS_SNAN) begin
            value_o   = make_quiet(z_i.raw);
            invalid_o = 1'b1;
        end else if (x_i.cls == CLS_SNAN) begin
            value_o   = make_quiet(x_i.raw);
            invalid_o = 1'b1;
        end else if (y_i.cls == CLS_SNAN) begin
            value_o   = make_quiet(y_i.raw);
            invalid_o = 1'b1;
        end else if (x_i.cls == CLS_QNAN) begin
            value_o = x_i.raw;
        end else if (y_i.cls == CLS_QNAN) begin
            value_o = y_i.raw;
        end else if ((x_inf && y_zero) || (x_zero && y_inf)) begin
            if (z_qnan) begin
                value_o = z_i.raw;
            end else begin
                value_o   = DEFAULT_NAN;
                invalid_o = 1'b1;
            end
        end else if (x_inf || y_inf) begin
            if (z_qnan) begin
                value_o = z_i.raw;
            end else if (z_inf && (z_i.sign != prod_sign)) begin
                value_o   = DEFAULT_NAN;
                invalid_o = 1'b1;
            end else begin
                value_o = inf_of(prod_sign);
            end
        end else if (x_zero || y_zero) begin
            value_o = z_inf ? inf_of(z_i.sign) : z_i.raw;
        end else begin
            if (z_qnan)      value_o  = z_i.raw;
            else if (z_inf)  value_o  = inf_of(z_i.sign);
            else             bypass_o = 1'b0;
        end
    end

    always_comb begin
        AST_INVALID_NEEDS_BYPASS: assert (!invalid_o || bypass_o)
            else $error("invalid raised without bypass"); // R9
        AST_SNAN_RAISES_INVALID: assert (!any_snan || (invalid_o && bypass_o))
            else $error("signalling operand did not raise invalid"); // R2
        AST_NO_SIGNALLING_RESULT: assert (!(bypass_o && (&value_o[DW-2:MW]) && (|value_o[MW-1:0])) || value_o[QBIT])
            else $error("signalling NaN escaped as result"); // R3
        AST_DATAPATH_CLEAN: assert (bypass_o || (!invalid_o && (value_o == '0)))
            else $error("datapath case carries flags or value"); // R8
        AST_QNAN_X_FORWARD: assert (any_snan || (x_i.cls != CLS_QNAN) || (value_o == x_i.raw))
            else $error("quiet NaN in X not forwarded"); // R4
        AST_ZERO_PRODUCT_NO_INVALID: assert (any_snan || is_nan(x_i.cls) || is_nan(y_i.cls) || x_inf || y_inf
                                             || !(x_zero || y_zero) || !invalid_o)
            else $error("zero product raised invalid"); // R7
    end

    logic unused_ok;
    assign unused_ok = is_finite_nonzero(z_i.cls);

endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
    import fma_special_pkg::*;
(
    input  logic [63:0] addend_i,
    input  logic [63:0] mulx_i,
    input  logic [63:0] muly_i,
    output logic        bypass_o,
    output logic [63:0] result_o,
    output logic        invalid_o,
    output logic        prenorm_z_o,
    output logic        prenorm_x_o,
    output logic        prenorm_y_o
);

    logic [DW-1:0]      raw_ops [NUM_OPS];
    fp_info_t           info    [NUM_OPS];
    logic [NUM_OPS-1:0] denorm;

    assign raw_ops[OP_Z] = addend_i;
    assign raw_ops[OP_X] = mulx_i;
    assign raw_ops[OP_Y] = muly_i;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
        fma_operand_classify u_cls (
            .raw_i    (raw_ops[g]),
            .info_o   (info[g]),
            .denorm_o (denorm[g])
        );
    end

    fma_special_select u_sel (
        .z_i       (info[OP_Z]),
        .x_i       (info[OP_X]),
        .y_i       (info[OP_Y]),
        .bypass_o  (bypass_o),
        .value_o   (result_o),
        .invalid_o (invalid_o)
    );

    assign prenorm_z_o = denorm[OP_Z];
    assign prenorm_x_o = denorm[OP_X];
    assign prenorm_y_o = denorm[OP_Y];

    always_comb begin
        AST_PRENORM_MATCHES_RAW: assert (prenorm_x_o == ((mulx_i[62:52] == '0) && (mulx_i[51:0] != '0)))
            else $error("prenorm flag disagrees with operand bits"); // R1
    end

endmodule

// File: tb/test_fma_special_resolver.sv
module test_fma_special_resolver;

    typedef struct {
        logic [63:0] val;
        logic        byp;
        logic        inv;
        logic [2:0]  pn;
        string       tag;
        string       note;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [63:0] z_in = '0, x_in = '0, y_in = '0;
    logic        bypass, invalid, pz, px, py;
    logic [63:0] result;

    fma_special_resolver i_fma_special_resolver (
        .addend_i   (z_in),
        .mulx_i     (x_in),
        .muly_i     (y_in),
        .bypass_o   (bypass),
        .result_o   (result),
        .invalid_o  (invalid),
        .prenorm_z_o(pz),
        .prenorm_x_o(px),
        .prenorm_y_o(py)
    );

    exp_item_t sb[$];
    exp_item_t cur;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [63:0] PZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] NTWO  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QN_A  = 64'h7FF8_0000_0000_1234;
    localparam logic [63:0] QN_B  = 64'hFFF8_0000_0000_5678;
    localparam logic [63:0] SN_A  = 64'h7FF0_0000_0000_0ABC;
    localparam logic [63:0] SN_B  = 64'hFFF4_0000_0000_0001;
    localparam logic [63:0] DEN   = 64'h0000_0000_0000_0001;
    localparam logic [63:0] NDEN  = 64'h800F_FFFF_FFFF_FFFF;
    localparam logic [63:0] DNAN  = 64'h7FF8_0000_0000_0000;

    // kinds: 0 zero, 1 denormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signalling NaN
    function automatic int kind(input logic [63:0] v);
        if (v[62:52] == 11'h7FF) begin
            if (v[51:0] == 0) return 3;
            return v[51] ? 4 : 5;
        end
        if (v[62:52] == 0) return (v[51:0] == 0) ? 0 : 1;
        return 2;
    endfunction

    function automatic exp_item_t model(input logic [63:0] z, input logic [63:0] x, input logic [63:0] y);
        exp_item_t e;
        int kz = kind(z), kx = kind(x), ky = kind(y);
        logic ps = x[63] ^ y[63];
        e.byp = 1'b1; e.inv = 1'b0; e.val = '0; e.note = "";
        e.pn  = {ky == 1, kx == 1, kz == 1};
        if (kz == 5)      begin e.tag = "R2"; e.val = z | (64'd1 << 51); e.inv = 1'b1; end
        else if (kx == 5) begin e.tag = "R3"; e.val = x | (64'd1 << 51); e.inv = 1'b1; end
        else if (ky == 5) begin e.tag = "R3"; e.val = y | (64'd1 << 51); e.inv = 1'b1; end
        else if (kx == 4) begin e.tag = "R4"; e.val = x; end
        else if (ky == 4) begin e.tag = "R4"; e.val = y; end
        else if ((kx == 3 && ky == 0) || (kx == 0 && ky == 3)) begin
            e.tag = "R5";
            if (kz == 4) e.val = z;
            else begin e.val = DNAN; e.inv = 1'b1; end
        end else if (kx == 3 || ky == 3) begin
            e.tag = "R6";
            if (kz == 4) e.val = z;
            else if (kz == 3 && z[63] != ps) begin e.val = DNAN; e.inv = 1'b1; end
            else e.val = {ps, 11'h7FF, 52'd0};
        end else if (kx == 0 || ky == 0) begin
            e.tag = "R7";
            e.val = (kz == 3) ? {z[63], 11'h7FF, 52'd0} : z;
        end else begin
            e.tag = "R8";
            if (kz == 4) e.val = z;
            else if (kz == 3) e.val = {z[63], 11'h7FF, 52'd0};
            else e.byp = 1'b0;
        end
        return e;
    endfunction

    task automatic apply(input logic [63:0] z, input logic [63:0] x, input logic [63:0] y, input string note);
        exp_item_t e;
        @(posedge clk);
        z_in = z; x_in = x; y_in = y;
        e = model(z, x, y);
        e.note = note;
        sb.push_back(e);
    endtask

    // monitor: outputs are combinational, compared at the falling edge after the drive
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            cur = sb.pop_front();
            checks++;
            if (result !== cur.val || bypass !== cur.byp) begin
                fails++;
                $display("FAIL %s %s: result=%h bypass=%b expected result=%h bypass=%b",
                         cur.tag, cur.note, result, bypass, cur.val, cur.byp);
            end
            checks++;
            if (invalid !== cur.inv) begin
                fails++;
                $display("FAIL %s/R9 %s: invalid=%b expected %b", cur.tag, cur.note, invalid, cur.inv);
            end
            checks++;
            if ({py, px, pz} !== cur.pn) begin
                fails++;
                $display("FAIL R1 %s: prenorm(y,x,z)=%b expected %b", cur.note, {py, px, pz}, cur.pn);
            end
        end
    end

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] vals [12];
        vals = '{PZERO, NZERO, ONE, NTWO, PINF, NINF, QN_A, QN_B, SN_A, SN_B, DEN, NDEN};
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state: all-zero operands, zero product returns the addend (R7)
        apply(PZERO, PZERO, PZERO, "idle zero");
        // R2 signalling addend beats signalling multiplicands
        apply(SN_A, SN_B, QN_A, "snan z first");
        // R3 x before y
        apply(QN_A, SN_A, SN_B, "snan x over y");
        apply(ONE, QN_B, SN_B, "snan y beats qnan x");
        // R4 qnan multiplicand beats qnan addend
        apply(QN_A, ONE, QN_B, "qnan y over qnan z");
        // R5 invalid product then a clean op (R9 clears)
        apply(ONE, PINF, NZERO, "inf*zero");
        apply(ONE, ONE, ONE, "clean after invalid");
        apply(QN_A, NZERO, NINF, "zero*inf qnan z");
        // R6 opposite and matching infinite addend
        apply(PINF, NINF, ONE, "inf prod vs opposite inf");
        apply(NINF, NINF, ONE, "inf prod vs same inf");
        apply(DEN, NINF, NDEN, "inf times denormal");
        // R7 zero product with infinite addend
        apply(NINF, PZERO, DEN, "zero prod inf z");
        // R8 datapath with denormal addend, R1 flags
        apply(NDEN, DEN, NTWO, "datapath denormals");
        // full cross product
        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
                for (int k = 0; k < 12; k++)
                    apply(vals[i], vals[j], vals[k], "sweep");
        wait (sb.size() == 0);
        @(posedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule